// File: doc/BRIEF.md
# Video Line Packet Sequencer

This block decides, for every video line, which packets a serial display link sends and in what order. A table of twelve 32-bit sequence slots holds the plan. Each slot can describe up to three packets, each with an enable bit, a 6-bit data type and a 3-bit pointer into a bank of eight byte-length registers. A slot can also ask for the lanes to drop to low-power once its packets are done. The slots are used in pairs, and each line plays one pair. An internal line counter picks the pair from where the line falls in the frame: the vsync-start line, the vsync-end line, the first active line, the later active lines, or an ordinary blanking line.

For each packet it plays, the block puts out a one-cycle descriptor strobe with a data type and a byte length, for a downstream packet builder. The slot and length tables, and the line numbers that mark vsync-end and the active region, are static configuration inputs. A timing generator pulses `line_start_i` at the start of each line and raises `frame_start_i` with it on the first line of a frame.

Top module: `dsi_line_sequencer`

## Requirements
- R1: The line index is 0 on a line whose start is accompanied by `frame_start_i`, and is one more than the previous accepted line otherwise. Index 0 plays slots 0 then 1. Otherwise, index equal to `vse_line_i` plays 2 then 3. Otherwise, an index equal to `act_first_i` plays 6 then 7, and an index within the next `act_lines_i - 1` lines plays 10 then 11. Every other index plays 4 then 5.
- R2: In a slot word, packet p (p = 0, 1, 2) takes its length pointer from bits [10p+2:10p], its data type from bits [10p+8:10p+3] and its enable from bit 10p+9. The strobe carries that data type on `pkt_dt_o`.
- R3: A packet whose enable bit is 0 produces no strobe in its cycle. A slot with no enabled packets emits nothing but still takes its three cycles.
- R4: `pkt_len_o` carries length register k, taken from `len_table_i[16k+15:16k]`, where k is the packet's length pointer.
- R5: If bit 30 of a slot word is set, `lp_req_o` is high for one cycle, in the same cycle as the strobe slot of that slot's third packet. Otherwise it stays low.
- R6: If a line is accepted at clock edge k, packet p of the first slot is presented after edge k+1+p, packet p of the second slot after edge k+4+p, and `busy_o` is high from edge k to edge k+6.
- R7: A `line_start_i` that arrives while a line is playing, other than in its final cycle, is ignored. It neither disturbs the line in progress nor advances the line index.
- R8: A `line_start_i` in the final cycle of a line, or while idle, is accepted. Back-to-back lines run with no idle cycle between them.
- R9: After reset `busy_o`, `pkt_valid_o` and `lp_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_table_i | input | 384 | Twelve slot words, slot s in bits [32s+31:32s] |
| len_table_i | input | 128 | Eight 16-bit byte-length registers |
| vse_line_i | input | 12 | Line index of the vsync-end line |
| act_first_i | input | 12 | Line index of the first active line |
| act_lines_i | input | 12 | Number of active lines |
| line_start_i | input | 1 | One-cycle pulse at the start of a line |
| frame_start_i | input | 1 | Marks the line started with it as index 0 |
| busy_o | output | 1 | A line is being played |
| pkt_valid_o | output | 1 | Descriptor strobe |
| pkt_dt_o | output | 6 | Packet data type |
| pkt_len_o | output | 16 | Packet byte length |
| lp_req_o | output | 1 | Low-power entry request at the end of a slot |

## Verification
Two things can land in the same cycle: the last step of one line, which may carry a low-power request, and the acceptance of the next line's start. The bench times a start pulse into the sixth cycle of a line whose second slot has its low-power bit set. It then checks that the request and the old line's last packet still come out, and that the new line's first packet follows one cycle later, taken from the pair that the next line index selects. A second directed case sends a start in the middle of a line. It checks that the running line completes unchanged and that the next accepted line gets the index it would have had without the stray pulse.

// File: rtl/dls_pkg.sv
`timescale 1ns/1ps
package dls_pkg;

    localparam int SLOT_BITS  = 32;
    localparam int PKT_STRIDE = 10;
    localparam int PKTS       = 3;
    localparam int LP_BIT     = 30;

    typedef struct packed {
        logic       en;
        logic [5:0] dt;
        logic [2:0] idx;
    } pkt_fld_t;

    // pair code times two is the first slot of the pair
    typedef enum logic [2:0] {
        PAIR_VS_START  = 3'd0,
        PAIR_VS_END    = 3'd1,
        PAIR_BLANK     = 3'd2,
        PAIR_ACT_FIRST = 3'd3,
        PAIR_ACT_NEXT  = 3'd5
    } pair_e;

    function automatic pkt_fld_t get_pkt(input logic [SLOT_BITS-1:0] w, input int p);
        pkt_fld_t f;
        f.idx = w[p*PKT_STRIDE +: 3];
        f.dt  = w[p*PKT_STRIDE + 3 +: 6];
        f.en  = w[p*PKT_STRIDE + 9];
        return f;
    endfunction

endpackage

// File: rtl/dls_line_class.sv
`timescale 1ns/1ps
module dls_line_class
    import dls_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              frame_i,
    input  logic [LINE_W-1:0] vse_line_i,
    input  logic [LINE_W-1:0] act_first_i,
    input  logic [LINE_W-1:0] act_lines_i,
    output pair_e             pair_o
);

    typedef struct packed {
        logic [LINE_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [LINE_W-1:0] idx;
    logic [LINE_W-1:0] rel;

    always_comb begin
        idx  = frame_i ? '0 : st_q.cnt;
        rel  = idx - act_first_i;
        st_d = st_q;
        if (idx == '0)
            pair_o = PAIR_VS_START;
        else if (idx == vse_line_i)
            pair_o = PAIR_VS_END;
        else if (idx >= act_first_i && rel < act_lines_i)
            pair_o = (rel == '0) ? PAIR_ACT_FIRST : PAIR_ACT_NEXT;
        else
            pair_o = PAIR_BLANK;
        if (accept_i)
            st_d.cnt = idx + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/dls_slot_walk.sv
`timescale 1ns/1ps
module dls_slot_walk
    import dls_pkg::*;
#(
    parameter int SLOTS    = 12,
    parameter int LEN_REGS = 8,
    parameter int LEN_W    = 16,
    localparam int SLOT_W  = $clog2(SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SLOTS*SLOT_BITS-1:0] seq_table_i,
    input  logic [LEN_REGS*LEN_W-1:0] len_table_i,
    input  logic                      start_i,
    input  logic [SLOT_W-1:0]         base_i,
    output logic                      accept_o,
    output logic                      busy_o,
    output logic                      vld_o,
    output logic [5:0]                dt_o,
    output logic [LEN_W-1:0]          len_o,
    output logic                      lp_o
);

    typedef struct packed {
        logic              busy;
        logic [SLOT_W-1:0] slot;
        logic [1:0]        pos;
        logic              vld;
        logic [5:0]        dt;
        logic [LEN_W-1:0]  len;
        logic              lp;
    } st_t;

    st_t st_d, st_q;
    logic [SLOT_BITS-1:0] word;
    pkt_fld_t fld;
    logic last_step;

    always_comb begin
        word      = seq_table_i[int'(st_q.slot)*SLOT_BITS +: SLOT_BITS];
        fld       = get_pkt(word, int'(st_q.pos));
        last_step = st_q.busy && st_q.slot[0] && (st_q.pos == 2'd2);
        accept_o  = start_i && (!st_q.busy || last_step);

        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.dt  = '0;
        st_d.len = '0;
        st_d.lp  = 1'b0;
        if (st_q.busy) begin
            if (fld.en) begin
                st_d.vld = 1'b1;
                st_d.dt  = fld.dt;
                st_d.len = len_table_i[int'(fld.idx)*LEN_W +: LEN_W];
            end
            if (st_q.pos == 2'd2) begin
                st_d.lp  = word[LP_BIT];
                st_d.pos = 2'd0;
                if (st_q.slot[0]) st_d.busy = 1'b0;
                else              st_d.slot = st_q.slot + 1'b1;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
        if (accept_o) begin
            st_d.busy = 1'b1;
            st_d.slot = base_i;
            st_d.pos  = 2'd0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign vld_o  = st_q.vld;
    assign dt_o   = st_q.dt;
    assign len_o  = st_q.len;
    assign lp_o   = st_q.lp;

endmodule

// File: rtl/dsi_line_sequencer.sv
`timescale 1ns/1ps
module dsi_line_sequencer
    import dls_pkg::*;
#(
    parameter int LINE_W   = 12,
    parameter int SLOTS    = 12,
    parameter int LEN_REGS = 8,
    parameter int LEN_W    = 16,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int SEQ_W   = SLOTS * SLOT_BITS,
    localparam int LENS_W  = LEN_REGS * LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEQ_W-1:0]  seq_table_i,
    input  logic [LENS_W-1:0] len_table_i,
    input  logic [LINE_W-1:0] vse_line_i,
    input  logic [LINE_W-1:0] act_first_i,
    input  logic [LINE_W-1:0] act_lines_i,
    input  logic              line_start_i,
    input  logic              frame_start_i,
    output logic              busy_o,
    output logic              pkt_valid_o,
    output logic [5:0]        pkt_dt_o,
    output logic [LEN_W-1:0]  pkt_len_o,
    output logic              lp_req_o
);

    pair_e             pair;
    logic              accept;
    logic [SLOT_W-1:0] base;

    assign base = SLOT_W'({pair, 1'b0});

    dls_line_class #(.LINE_W(LINE_W)) u_class (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .frame_i     (frame_start_i),
        .vse_line_i  (vse_line_i),
        .act_first_i (act_first_i),
        .act_lines_i (act_lines_i),
        .pair_o      (pair)
    );

    dls_slot_walk #(
        .SLOTS    (SLOTS),
        .LEN_REGS (LEN_REGS),
        .LEN_W    (LEN_W)
    ) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .seq_table_i (seq_table_i),
        .len_table_i (len_table_i),
        .start_i     (line_start_i),
        .base_i      (base),
        .accept_o    (accept),
        .busy_o      (busy_o),
        .vld_o       (pkt_valid_o),
        .dt_o        (pkt_dt_o),
        .len_o       (pkt_len_o),
        .lp_o        (lp_req_o)
    );

endmodule

// File: rtl/dls_chk.sv
`timescale 1ns/1ps
module dls_chk (
    input logic clk,
    input logic rst_n,
    input logic line_start_i,
    input logic busy_o,
    input logic pkt_valid_o,
    input logic lp_req_o
);

    p_pkt_inside_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid_o |-> $past(busy_o));

    p_lp_inside_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lp_req_o |-> $past(busy_o));

    p_idle_start_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start_i && !busy_o) |=> busy_o);

    p_busy_needs_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(line_start_i));

endmodule

bind dsi_line_sequencer dls_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_start_i (line_start_i),
    .busy_o       (busy_o),
    .pkt_valid_o  (pkt_valid_o),
    .lp_req_o     (lp_req_o)
);

// File: tb/sim_dsi_line_sequencer.sv
`timescale 1ns/1ps
module sim_dsi_line_sequencer;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [383:0] seq_table;
    logic [127:0] len_table;
    logic [11:0]  vse_line = 12'd2;
    logic [11:0]  act_first = 12'd4;
    logic [11:0]  act_lines = 12'd3;
    logic         line_start = 1'b0;
    logic         frame_start = 1'b0;
    logic         busy, pkt_valid, lp_req;
    logic [5:0]   pkt_dt;
    logic [15:0]  pkt_len;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dsi_line_sequencer u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .seq_table_i   (seq_table),
        .len_table_i   (len_table),
        .vse_line_i    (vse_line),
        .act_first_i   (act_first),
        .act_lines_i   (act_lines),
        .line_start_i  (line_start),
        .frame_start_i (frame_start),
        .busy_o        (busy),
        .pkt_valid_o   (pkt_valid),
        .pkt_dt_o      (pkt_dt),
        .pkt_len_o     (pkt_len),
        .lp_req_o      (lp_req)
    );

    // frame bit, expected first slot of the pair (R1)
    localparam logic [4:0] LINES [11] = '{
        5'b1_0000, 5'b0_0100, 5'b0_0010, 5'b0_0100, 5'b0_0110, 5'b0_1010,
        5'b0_1010, 5'b0_0100, 5'b0_0100, 5'b1_0000, 5'b0_0100
    };

    function automatic logic [31:0] mk_slot(input int s);
        logic [31:0] w = '0;
        if (s == 5) return '0;
        for (int p = 0; p < 3; p++) begin
            w[10*p+9]     = ((s + p) % 4) != 3;
            w[10*p+3 +: 6] = 6'(s*4 + p + 1);
            w[10*p +: 3]  = 3'((s + p) % 8);
        end
        w[30] = (s % 3) != 2;
        return w;
    endfunction

    function automatic logic [15:0] mk_len(input int k);
        return 16'(16'h1000 + k * 16'h0111);
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // position i (1..6) after accepted edge k of a line whose pair starts at base
    task automatic check_pos(input int base, input int i, input string tag);
        int s = base + (i - 1) / 3;
        int p = (i - 1) % 3;
        logic [31:0] w = mk_slot(s);
        logic en = w[10*p+9];
        chk(pkt_valid == en, $sformatf("%s R3 valid slot%0d pkt%0d", tag, s, p), pkt_valid, en);
        if (en) begin
            chk(pkt_dt == w[10*p+3 +: 6], $sformatf("%s R2 dtype slot%0d pkt%0d", tag, s, p),
                pkt_dt, w[10*p+3 +: 6]);
            chk(pkt_len == mk_len(w[10*p +: 3]), $sformatf("%s R4 length slot%0d pkt%0d", tag, s, p),
                pkt_len, mk_len(w[10*p +: 3]));
        end
        chk(lp_req == ((p == 2) ? w[30] : 1'b0), $sformatf("%s R5 lowpower slot%0d pos%0d", tag, s, i),
            lp_req, (p == 2) ? w[30] : 1'b0);
    endtask

    task automatic run_line(input bit f, input int base, input string tag);
        @(negedge clk);
        line_start  = 1'b1;
        frame_start = f;
        @(negedge clk);
        line_start  = 1'b0;
        frame_start = 1'b0;
        chk(busy == 1'b1, {tag, " R6 busy at start"}, busy, 1);
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            check_pos(base, i, tag);
        end
        chk(busy == 1'b0, {tag, " R6 idle after six cycles"}, busy, 0);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 12; s++) seq_table[32*s +: 32] = mk_slot(s);
        for (int k = 0; k < 8; k++) len_table[16*k +: 16] = mk_len(k);

        // R9: reset state
        repeat (3) @(negedge clk);
        chk(busy == 0 && pkt_valid == 0 && lp_req == 0, "R9 outputs during reset",
            {busy, pkt_valid, lp_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 0 && pkt_valid == 0 && lp_req == 0, "R9 outputs after reset",
            {busy, pkt_valid, lp_req}, 0);

        // R1 table walk over a frame and into the next
        for (int n = 0; n < 11; n++)
            run_line(LINES[n][4], int'(LINES[n][3:0]), $sformatf("R1 line%0d", n));

        // R8: back-to-back lines, start lands with slot 1 low-power request
        @(negedge clk);
        line_start = 1'b1; frame_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0; frame_start = 1'b0;
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            check_pos(0, i, "R8 first");
        end
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        check_pos(0, 6, "R8 overlap");
        chk(busy == 1'b1, "R8 busy kept across boundary", busy, 1);
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            check_pos(4, i, "R8 second");
        end

        // R7: start during a line is ignored and does not advance the index
        @(negedge clk);
        line_start = 1'b1; frame_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0; frame_start = 1'b0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            check_pos(0, i, "R7 running");
            if (i == 2) line_start = 1'b1;
            else        line_start = 1'b0;
        end
        line_start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && pkt_valid == 1'b0, "R7 no extra line", {busy, pkt_valid}, 0);
        run_line(1'b0, 4, "R7 next index");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule